// File: doc/BRIEF.md
# Clock-generator configuration slave on a two-wire management bus

This block is the management-bus slave of a clock generator. It watches the clock and data lines of a two-wire bus through synchronisers, finds START, repeated START and STOP conditions, and answers one fixed pair of 8-bit address bytes: 0xDC opens a write and 0xDD opens a read. The data line is modelled as an open-drain pad: the block only asserts an output enable that pulls the line low, and the pad data value is always 0.

Every transfer is indexed. A write sends a start index, then a byte count, then that many data bytes into consecutive registers. A read first sends the start index with the write address. A repeated START then brings the read address. The slave answers with the programmed byte count, then with data from the start index onward, until the master refuses a byte. The register file holds seven bytes. They are a control byte whose frequency and spread fields start from strap pins sampled during reset, output enables, output stop modes, a read-only strap readback, two fixed identity bytes and the read byte-count register. The register contents drive configuration outputs that the rest of the clock generator uses directly.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges the address byte 0xDC (write) and 0xDD (read) and leaves the ninth bit high for any other address byte, then stays silent until the next START.
- R2: In a write, the byte after the address is the start index and the next one is the byte count X. Each of the following X data bytes is acknowledged and stored at the current index.
- R3: A data byte that arrives after X bytes of a write have been taken is not acknowledged and changes no register.
- R4: After a repeated START and the read address, the first byte returned is the content of index 6. After that the slave returns index contents from the start index onward, for as long as the master acknowledges.
- R5: The index advances by one after each stored or returned data byte and goes from 6 back to 0. A start index of 7 or more selects index 0.
- R6: Index 0 holds the frequency select in bits 7..4, spread enable in bit 3, software select in bit 2, stop drive mode in bit 1 and spread type in bit 0. Bits 2 and 1 take every write. Bits 7..3 and bit 0 take a write only while the stored bit 2 is 1.
- R7: Index 3 always reads {strap frequency[3:0], strap spread enable, 0, 0, strap spread type}, sampled while reset is low.
- R8: After reset, index 0 is {strap frequency, strap spread enable, 0, 0, strap spread type}, index 1 is 0xFF, index 2 is 0x80 and index 6 is 0x07. Index 4 reads 0x01 and index 5 reads 0x07. Writes to indices 3, 4 and 5 are acknowledged and have no effect.
- R9: The slave changes its pull on the data line only while the synchronised clock line is low, and the pad data value is always 0.
- R10: The configuration outputs always show index 0 bit by bit (frequency select, spread enable, software select, stop drive mode, spread type), index 1 as the output enables and index 2 as the stop modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset; the straps are sampled while it is low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_o | output | 1 | Pad data value, tied to 0 |
| sda_oe | output | 1 | Pad enable; 1 pulls the data line low |
| strap_fs | input | 4 | Frequency select strap pins |
| strap_spread | input | 1 | Spread enable strap pin |
| strap_center | input | 1 | Spread type strap pin |
| cfg_fs | output | 4 | Frequency select in use |
| cfg_spread_en | output | 1 | Spread enable in use |
| cfg_sw_sel | output | 1 | Software select bit |
| cfg_stop_hiz | output | 1 | Stop drive mode (0 driven, 1 high impedance) |
| cfg_center | output | 1 | Spread type (0 down, 1 center) |
| out_enable | output | 8 | Per-output enables |
| stop_able | output | 8 | Per-output stop-mode selects |

## Verification
The checker covers the properties that hold at every edge. The data-line pull changes only while the clock line is low. A register store is always followed by an acknowledge and never targets an index past 6. The frequency and spread fields stay unchanged while software select is clear. The strap readback never moves after reset. Other behaviour shows only in whole bus transfers, and the bench's scenarios drive those: the index count and wrap, the refusal of surplus write bytes, the byte count that leads a read, wrong addresses, and writes that leave read-only indices unchanged.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int NREG  = 7;
  localparam int IDX_W = $clog2(NREG);
  localparam int DW    = 8;

  localparam logic [DW-1:0] ADDR_WR   = 8'hDC;
  localparam logic [DW-1:0] ADDR_RD   = 8'hDD;
  localparam logic [DW-1:0] RST_OE    = 8'hFF;
  localparam logic [DW-1:0] RST_STOP  = 8'h80;
  localparam logic [DW-1:0] RST_BCNT  = 8'h07;
  localparam logic [DW-1:0] ID_REVVND = 8'h01;
  localparam logic [DW-1:0] ID_DEV    = 8'h07;
  // control byte bits that always accept a write (software select, stop drive)
  localparam logic [DW-1:0] CTL_FREE  = 8'h06;

  localparam logic [IDX_W-1:0] IDX_CTL  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_OE   = 3'd1;
  localparam logic [IDX_W-1:0] IDX_STOP = 3'd2;
  localparam logic [IDX_W-1:0] IDX_RB   = 3'd3;
  localparam logic [IDX_W-1:0] IDX_ID0  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_ID1  = 3'd5;
  localparam logic [IDX_W-1:0] IDX_BCNT = 3'd6;

  typedef enum logic [2:0] {
    BUS_IDLE, BUS_RX, BUS_RX_ACK, BUS_TX, BUS_TX_ACK
  } bus_state_t;

  function automatic logic [IDX_W-1:0] idx_next(input logic [IDX_W-1:0] i);
    return (int'(i) == NREG - 1) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [IDX_W-1:0] idx_clip(input logic [DW-1:0] n);
    return (int'(n) < NREG) ? n[IDX_W-1:0] : '0;
  endfunction

  function automatic logic [DW-1:0] ctl_merge(input logic [DW-1:0] old,
                                              input logic [DW-1:0] wd);
    return old[2] ? wd : ((old & ~CTL_FREE) | (wd & CTL_FREE));
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            scl_pipe[0] <= 1'b1;
            sda_pipe[0] <= 1'b1;
          end else begin
            scl_pipe[0] <= scl_i;
            sda_pipe[0] <= sda_i;
          end
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            scl_pipe[g] <= 1'b1;
            sda_pipe[g] <= 1'b1;
          end else begin
            scl_pipe[g] <= scl_pipe[g-1];
            sda_pipe[g] <= sda_pipe[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_bus_fsm.sv
module smb_bus_fsm
  import smb_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic [DW-1:0]    rd_data,
  input  logic [DW-1:0]    bcnt,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [DW-1:0]    wr_data,
  output logic             sda_drive
);
  bus_state_t       state;
  logic [DW-1:0]    shreg;
  logic [3:0]       bitcnt;
  logic [1:0]       byte_no;   // 0 address, 1 index, 2 count, 3 data
  logic [IDX_W-1:0] ptr;
  logic [DW-1:0]    remain;
  logic             go_tx;
  logic             m_ack;
  logic             byte_end;
  logic             rx_ack;

  assign byte_end = (state == BUS_RX) && scl_fall && (bitcnt == 4'd8);

  always_comb begin
    unique case (byte_no)
      2'd0:    rx_ack = (shreg == ADDR_WR) || (shreg == ADDR_RD);
      2'd3:    rx_ack = (remain != '0);
      default: rx_ack = 1'b1;
    endcase
  end

  assign wr_en   = byte_end && (byte_no == 2'd3) && (remain != '0);
  assign wr_idx  = ptr;
  assign wr_data = shreg;
  assign rd_idx  = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= BUS_IDLE;
      shreg     <= '0;
      bitcnt    <= '0;
      byte_no   <= '0;
      ptr       <= '0;
      remain    <= '0;
      go_tx     <= 1'b0;
      m_ack     <= 1'b0;
      sda_drive <= 1'b0;
    end else if (start_ev) begin
      state     <= BUS_RX;
      bitcnt    <= '0;
      byte_no   <= '0;
      sda_drive <= 1'b0;
    end else if (stop_ev) begin
      state     <= BUS_IDLE;
      sda_drive <= 1'b0;
    end else begin
      unique case (state)
        BUS_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[DW-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_end) begin
            if (rx_ack) begin
              sda_drive <= 1'b1;
              state     <= BUS_RX_ACK;
            end else begin
              state <= BUS_IDLE;
            end
            if (byte_no != 2'd3) byte_no <= byte_no + 1'b1;
            unique case (byte_no)
              2'd0: go_tx  <= (shreg == ADDR_RD);
              2'd1: ptr    <= idx_clip(shreg);
              2'd2: remain <= shreg;
              default: begin
                if (remain != '0) begin
                  ptr    <= idx_next(ptr);
                  remain <= remain - 1'b1;
                end
              end
            endcase
          end
        end
        BUS_RX_ACK: begin
          if (scl_fall) begin
            if (go_tx) begin
              state     <= BUS_TX;
              sda_drive <= ~bcnt[DW-1];
              shreg     <= {bcnt[DW-2:0], 1'b0};
              bitcnt    <= 4'd1;
            end else begin
              state     <= BUS_RX;
              sda_drive <= 1'b0;
              bitcnt    <= '0;
            end
          end
        end
        BUS_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_drive <= 1'b0;
              state     <= BUS_TX_ACK;
            end else begin
              sda_drive <= ~shreg[DW-1];
              shreg     <= {shreg[DW-2:0], 1'b0};
              bitcnt    <= bitcnt + 1'b1;
            end
          end
        end
        BUS_TX_ACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (m_ack) begin
              state     <= BUS_TX;
              sda_drive <= ~rd_data[DW-1];
              shreg     <= {rd_data[DW-2:0], 1'b0};
              bitcnt    <= 4'd1;
              ptr       <= idx_next(ptr);
            end else begin
              state <= BUS_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       strap_fs,
  input  logic             strap_spread,
  input  logic             strap_center,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic [DW-1:0]    ctl_q,
  output logic [DW-1:0]    oe_q,
  output logic [DW-1:0]    stop_q,
  output logic [DW-1:0]    bcnt_q,
  output logic [DW-1:0]    strap_rb
);
  logic [5:0] strap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strap_q <= {strap_fs, strap_spread, strap_center};
      ctl_q   <= {strap_fs, strap_spread, 2'b00, strap_center};
      oe_q    <= RST_OE;
      stop_q  <= RST_STOP;
      bcnt_q  <= RST_BCNT;
    end else if (wr_en) begin
      unique case (wr_idx)
        IDX_CTL:  ctl_q  <= ctl_merge(ctl_q, wr_data);
        IDX_OE:   oe_q   <= wr_data;
        IDX_STOP: stop_q <= wr_data;
        IDX_BCNT: bcnt_q <= wr_data;
        default:  ;
      endcase
    end
  end

  assign strap_rb = {strap_q[5:1], 2'b00, strap_q[0]};

  always_comb begin
    unique case (rd_idx)
      IDX_CTL:  rd_data = ctl_q;
      IDX_OE:   rd_data = oe_q;
      IDX_STOP: rd_data = stop_q;
      IDX_RB:   rd_data = strap_rb;
      IDX_ID0:  rd_data = ID_REVVND;
      IDX_ID1:  rd_data = ID_DEV;
      IDX_BCNT: rd_data = bcnt_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_o,
  output logic       sda_oe,
  input  logic [3:0] strap_fs,
  input  logic       strap_spread,
  input  logic       strap_center,
  output logic [3:0] cfg_fs,
  output logic       cfg_spread_en,
  output logic       cfg_sw_sel,
  output logic       cfg_stop_hiz,
  output logic       cfg_center,
  output logic [7:0] out_enable,
  output logic [7:0] stop_able
);
  logic             scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic             wr_en;
  logic [DW-1:0]    wr_data, rd_data, ctl_q, oe_q, stop_q, bcnt_q, strap_rb;

  smb_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  smb_bus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .rd_data(rd_data), .bcnt(bcnt_q), .rd_idx(rd_idx), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .sda_drive(sda_oe)
  );

  smb_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .strap_fs(strap_fs), .strap_spread(strap_spread),
    .strap_center(strap_center), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .ctl_q(ctl_q),
    .oe_q(oe_q), .stop_q(stop_q), .bcnt_q(bcnt_q), .strap_rb(strap_rb)
  );

  assign sda_o         = 1'b0;
  assign cfg_fs        = ctl_q[7:4];
  assign cfg_spread_en = ctl_q[3];
  assign cfg_sw_sel    = ctl_q[2];
  assign cfg_stop_hiz  = ctl_q[1];
  assign cfg_center    = ctl_q[0];
  assign out_enable    = oe_q;
  assign stop_able     = stop_q;
endmodule

// File: rtl/smb_cfg_checker.sv
module smb_cfg_checker
  import smb_cfg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_o,
  input logic             sda_oe,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [3:0]       cfg_fs,
  input logic             cfg_spread_en,
  input logic             cfg_center,
  input logic             cfg_sw_sel,
  input logic [DW-1:0]    strap_rb
);
  // R9: pull changes only while clock line low
  assert_pull_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  // R9: pad data value is always 0
  assert_pad_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> !sda_o);

  // R2: every stored byte is acknowledged
  assert_store_acked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe);

  // R5: stores stay inside the implemented index range
  assert_store_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NREG));

  // R6: frequency and spread fields hold while software select is clear
  assert_fields_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_sw_sel) |-> ($stable(cfg_fs) && $stable(cfg_spread_en) && $stable(cfg_center)));

  // R7: strap readback never moves after reset
  assert_strap_rb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(strap_rb));
endmodule

bind smb_cfg_slave smb_cfg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_o(sda_o), .sda_oe(sda_oe),
  .wr_en(wr_en), .wr_idx(wr_idx), .cfg_fs(cfg_fs), .cfg_spread_en(cfg_spread_en),
  .cfg_center(cfg_center), .cfg_sw_sel(cfg_sw_sel), .strap_rb(strap_rb)
);

// File: tb/sim_smb_cfg_slave.sv
module sim_smb_cfg_slave;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_o, sda_oe, sda_bus;
  logic [3:0] st_fs = 4'b1010;
  logic       st_spread = 1'b1, st_center = 1'b1;
  logic [3:0] cfg_fs;
  logic       cfg_spread_en, cfg_sw_sel, cfg_stop_hiz, cfg_center;
  logic [7:0] out_enable, stop_able;

  assign sda_bus = sda_m & ~(sda_oe & ~sda_o);

  smb_cfg_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_o(sda_o),
    .sda_oe(sda_oe), .strap_fs(st_fs), .strap_spread(st_spread),
    .strap_center(st_center), .cfg_fs(cfg_fs), .cfg_spread_en(cfg_spread_en),
    .cfg_sw_sel(cfg_sw_sel), .cfg_stop_hiz(cfg_stop_hiz), .cfg_center(cfg_center),
    .out_enable(out_enable), .stop_able(stop_able)
  );

  int tests = 0, fails = 0;
  bit cmp_on = 0, done = 0;
  logic [7:0] mreg [0:6];
  logic [7:0] wbuf [0:7];

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // reference model of a register store
  function automatic void mwrite(input int i, input logic [7:0] d);
    case (i)
      0: mreg[0] = mreg[0][2] ? d : {mreg[0][7:3], d[2:1], mreg[0][0]};
      1, 2, 6: mreg[i] = d;
      default: ;
    endcase
  endfunction

  function automatic int wrap(input int i);
    return (i >= 6) ? 0 : i + 1;
  endfunction

  // per-clock comparison of configuration outputs (R10), while the bus clock is high
  always @(negedge clk) begin
    if (rst_n && cmp_on && scl_m) begin
      chk("R10 cfg", {cfg_fs, cfg_spread_en, cfg_sw_sel, cfg_stop_hiz, cfg_center}, mreg[0]);
      chk("R10 oe", out_enable, mreg[1]);
      chk("R10 stop", stop_able, mreg[2]);
    end
  end

  task automatic hclk(); repeat (10) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1; scl_m = 1; hclk(); sda_m = 0; hclk(); scl_m = 0; hclk();
  endtask
  task automatic bus_rstart();
    sda_m = 1; hclk(); scl_m = 1; hclk(); sda_m = 0; hclk(); scl_m = 0; hclk();
  endtask
  task automatic bus_stop();
    sda_m = 0; hclk(); scl_m = 1; hclk(); sda_m = 1; hclk();
  endtask

  task automatic wr_byte(input logic [7:0] b, input bit upd, input int uidx, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hclk(); scl_m = 1; hclk(); scl_m = 0;
    end
    sda_m = 1;
    if (upd) mwrite(uidx, b);
    hclk(); scl_m = 1;
    repeat (5) @(negedge clk);
    ack = !sda_bus;
    repeat (5) @(negedge clk);
    scl_m = 0;
  endtask

  task automatic rd_byte(input bit ack_it, output logic [7:0] b);
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      hclk(); scl_m = 1;
      repeat (5) @(negedge clk);
      b = {b[6:0], sda_bus};
      repeat (5) @(negedge clk);
      scl_m = 0;
    end
    sda_m = ack_it ? 1'b0 : 1'b1;
    hclk(); scl_m = 1; hclk(); scl_m = 0;
    hclk(); sda_m = 1;
  endtask

  task automatic blk_write(input logic [7:0] idx, input logic [7:0] cnt, input int n);
    bit ack;
    int p;
    p = (idx < 7) ? int'(idx) : 0;
    bus_start();
    wr_byte(8'hDC, 0, 0, ack); chk("R1 write address ack", {7'd0, ack}, 8'd1);
    wr_byte(idx, 0, 0, ack);   chk("R2 index ack", {7'd0, ack}, 8'd1);
    wr_byte(cnt, 0, 0, ack);   chk("R2 count ack", {7'd0, ack}, 8'd1);
    for (int i = 0; i < n; i++) begin
      bit take;
      take = (i < int'(cnt));
      wr_byte(wbuf[i], take, p, ack);
      if (take) begin
        chk("R2 data ack", {7'd0, ack}, 8'd1);
        p = wrap(p);
      end else begin
        chk("R3 surplus byte nack", {7'd0, ack}, 8'd0);
      end
    end
    bus_stop();
  endtask

  task automatic blk_read(input logic [7:0] idx, input int n);
    bit ack;
    int p;
    logic [7:0] b;
    p = (idx < 7) ? int'(idx) : 0;
    bus_start();
    wr_byte(8'hDC, 0, 0, ack); chk("R1 write address ack", {7'd0, ack}, 8'd1);
    wr_byte(idx, 0, 0, ack);   chk("R4 index ack", {7'd0, ack}, 8'd1);
    bus_rstart();
    wr_byte(8'hDD, 0, 0, ack); chk("R1 read address ack", {7'd0, ack}, 8'd1);
    rd_byte(1, b);             chk("R4 count byte", b, mreg[6]);
    for (int i = 0; i < n; i++) begin
      rd_byte(i < n - 1, b);
      chk($sformatf("R4 R5 data idx %0d", p), b, mreg[p]);
      p = wrap(p);
    end
    bus_stop();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    mreg[0] = {4'b1010, 1'b1, 2'b00, 1'b1};
    mreg[1] = 8'hFF; mreg[2] = 8'h80;
    mreg[3] = {4'b1010, 1'b1, 2'b00, 1'b1};
    mreg[4] = 8'h01; mreg[5] = 8'h07; mreg[6] = 8'h07;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R8 reset state at the ports
    chk("R8 reset ctl", {cfg_fs, cfg_spread_en, cfg_sw_sel, cfg_stop_hiz, cfg_center}, 8'hA9);
    chk("R8 reset oe", out_enable, 8'hFF);
    chk("R8 reset stop", stop_able, 8'h80);
    chk("R9 idle release", {7'd0, sda_oe}, 8'd0);
    cmp_on = 1;

    // R4 R7 R8: full read of the register file
    blk_read(8'd0, 7);

    // R1: foreign address is refused and ignored
    bus_start();
    wr_byte(8'hA0, 0, 0, ack); chk("R1 foreign address nack", {7'd0, ack}, 8'd0);
    bus_stop();

    // R2: enables and stop modes
    wbuf[0] = 8'h5A; wbuf[1] = 8'h3C;
    blk_write(8'd1, 8'd2, 2);
    chk("R2 R10 oe", out_enable, 8'h5A);
    chk("R2 R10 stop", stop_able, 8'h3C);

    // R6: gated fields while software select clear
    wbuf[0] = 8'hF2;
    blk_write(8'd0, 8'd1, 1);
    chk("R6 gated write", {cfg_fs, cfg_spread_en, cfg_sw_sel, cfg_stop_hiz, cfg_center}, 8'hAB);
    wbuf[0] = 8'h04;
    blk_write(8'd0, 8'd1, 1);
    chk("R6 set select", {cfg_fs, cfg_spread_en, cfg_sw_sel, cfg_stop_hiz, cfg_center}, 8'hAD);
    wbuf[0] = 8'h5C;
    blk_write(8'd0, 8'd1, 1);
    chk("R6 open write", {cfg_fs, cfg_spread_en, cfg_sw_sel, cfg_stop_hiz, cfg_center}, 8'h5C);

    // R8 R7: read-only indices keep their values
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF;
    blk_write(8'd3, 8'd3, 3);
    blk_read(8'd3, 4);

    // R5: wrap from index 6 to index 0
    wbuf[0] = 8'h03; wbuf[1] = 8'h11;
    blk_write(8'd6, 8'd2, 2);
    chk("R5 wrap store", {cfg_fs, cfg_spread_en, cfg_sw_sel, cfg_stop_hiz, cfg_center}, 8'h11);
    blk_read(8'd5, 3);

    // R3: surplus byte refused
    wbuf[0] = 8'hAA; wbuf[1] = 8'h55;
    blk_write(8'd1, 8'd1, 2);
    chk("R3 surplus ignored", out_enable, 8'hAA);

    // R5: out-of-range start index selects 0
    wbuf[0] = 8'h06;
    blk_write(8'd9, 8'd1, 1);
    chk("R5 clipped index", {cfg_fs, cfg_spread_en, cfg_sw_sel, cfg_stop_hiz, cfg_center}, 8'h17);

    blk_read(8'd0, 7);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule